// File: doc/BRIEF.md
# Four-Candidate Block SAD Engine

This engine scores one source block of high-bit-depth pixels against four candidate reference blocks in a single pass, as a motion search needs. Each accepted beat carries one source row and the matching row of all four candidates. Every sample term is the absolute difference between a candidate sample and the source sample at the same position. The engine returns four 32-bit sums of absolute differences together at the end of the block.

A start pulse latches the block width (16, 32 or 64 samples), the height (8, 16, 32 or 64 rows) and a row-skip flag, and it clears every accumulator. Inside, sixteen lanes per candidate gather partial sums in 16-bit registers. These registers are folded into 32-bit lane totals often enough that they never wrap. The width sets the fold interval. The last row of a block always forces a fold. In skip mode the caller sends only every other row, so half the height is expected, and each result is doubled. Row fetch and alignment happen upstream.

Top module: `quad_sad_engine`

## Requirements
- R1: Each of the four results equals the sum over all used positions and accepted rows of |ref − src| for its own candidate, all four sharing the same source row. Samples are 16-bit slots holding values 0..4095. Source sample j sits at `src_row_i[16j+15:16j]`, and sample j of candidate k at `ref_row_i[1024k+16j+15:1024k+16j]`. Result k is `sad_o[32k+31:32k]`.
- R2: `width_sel_i` encodes 0 = 16, 1 = 32 and 2 or 3 = 64 samples. Positions at or above the width do not affect any result.
- R3: Without skip, exactly `height_i` beats are consumed per block.
- R4: Partial sums never wrap. They fold every 16 rows at width 16, every 8 rows at width 32, every 2 rows at width 64, and on the last row. Results are exact even when every term is 4095.
- R5: With `skip_i` set, `height_i`/2 beats are consumed and every result is twice the sum of those beats.
- R6: A start accepted while idle clears all state, so each block's results are independent of earlier blocks.
- R7: `done_o` is a one-cycle pulse. All four results are valid in that cycle and stay unchanged until the next pulse.
- R8: `row_ready_o` is high only while a block is in progress. Beats offered after the last row are not consumed.
- R9: A start pulse during a block in progress is ignored, and the configuration in use does not change.
- R10: After reset, `done_o` and `row_ready_o` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block, honoured only when idle |
| width_sel_i | input | 2 | Block width code |
| height_i | input | 7 | Block height in rows |
| skip_i | input | 1 | Row-skip mode |
| row_valid_i | input | 1 | Row beat offered |
| row_ready_o | output | 1 | Engine accepts row beats |
| src_row_i | input | 1024 | Source row, 64 sample slots |
| ref_row_i | input | 4096 | Four candidate rows |
| done_o | output | 1 | Results valid pulse |
| sad_o | output | 128 | Four 32-bit results |

## Verification
The bench runs every width, height and skip combination twice. One pass uses random samples with garbage above the width. The other uses blocks in which every term is 4095. An engine that folded too late would lose carries and fall short on the all-maximum blocks, and an engine that failed to mask unused positions would report inflated sums. Further cases keep the row valid asserted past the last row, pulse start mid-block and send blocks back to back. A counting slip would then show up as a wrong total or a dropped done pulse, and a mid-block restart as corrupted results.

// File: rtl/quad_sad_pkg.sv
package quad_sad_pkg;
  localparam int SAMPLE_W = 16;
  localparam int LANES    = 16;
  localparam int MAX_W    = 64;
  localparam int NREF     = 4;
  localparam int PART_W   = 16;
  localparam int TOT_W    = 32;
  localparam int HGT_W    = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_REDUCE} sad_state_e;

  function automatic logic [SAMPLE_W-1:0] abs_diff(input logic [SAMPLE_W-1:0] a,
                                                   input logic [SAMPLE_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [7:0] width_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd16;
      2'd1:    return 8'd32;
      default: return 8'd64;
    endcase
  endfunction

  function automatic logic [4:0] fold_rows(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd16;
      2'd1:    return 5'd8;
      default: return 5'd2;
    endcase
  endfunction
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import quad_sad_pkg::*;
#(
  parameter int H_W = HGT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     width_sel_i,
  input  logic [H_W-1:0] height_i,
  input  logic           skip_i,
  input  logic           row_valid_i,
  output logic           row_ready_o,
  output logic           fire_o,
  output logic           fold_o,
  output logic           clr_o,
  output logic           reduce_o,
  output logic [1:0]     width_q_o,
  output logic           skip_q_o
);
  sad_state_e     state;
  logic [H_W-1:0] beat_cnt, beats_total;
  logic [4:0]     grp_cnt;
  logic           last_beat, group_end;

  assign clr_o       = start_i && (state == ST_IDLE);
  assign row_ready_o = (state == ST_RUN);
  assign fire_o      = row_ready_o && row_valid_i;
  assign last_beat   = (beat_cnt == beats_total - H_W'(1));
  assign group_end   = (grp_cnt == fold_rows(width_q_o) - 5'd1);
  assign fold_o      = fire_o && (group_end || last_beat);
  assign reduce_o    = (state == ST_REDUCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      beat_cnt    <= '0;
      beats_total <= '0;
      grp_cnt     <= '0;
      width_q_o   <= '0;
      skip_q_o    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          width_q_o   <= width_sel_i;
          skip_q_o    <= skip_i;
          beats_total <= skip_i ? (height_i >> 1) : height_i;
          beat_cnt    <= '0;
          grp_cnt     <= '0;
          state       <= ST_RUN;
        end
        ST_RUN: if (fire_o) begin
          beat_cnt <= beat_cnt + H_W'(1);
          grp_cnt  <= group_end ? 5'd0 : grp_cnt + 5'd1;
          if (last_beat) state <= ST_REDUCE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  beat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (beat_cnt < beats_total));
  // R4
  group_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (grp_cnt < fold_rows(width_q_o)));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN) && start_i) |=> ($stable(width_q_o) && $stable(skip_q_o)));
endmodule

// File: rtl/sad_ref_path.sv
module sad_ref_path
  import quad_sad_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      fire_i,
  input  logic                      fold_i,
  input  logic [1:0]                width_sel_i,
  input  logic [MAX_W*SAMPLE_W-1:0] src_row_i,
  input  logic [MAX_W*SAMPLE_W-1:0] ref_row_i,
  output logic [LANES*TOT_W-1:0]    totals_o
);
  logic [PART_W-1:0] lane_row  [LANES];
  logic [PART_W-1:0] part      [LANES];
  logic [PART_W-1:0] next_part [LANES];
  logic [TOT_W-1:0]  tot       [LANES];
  logic              carry, part_zero, tot_zero;

  always_comb begin
    carry     = 1'b0;
    part_zero = 1'b1;
    tot_zero  = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      logic [PART_W:0] wide;
      lane_row[l] = '0;
      for (int g = 0; g < MAX_W / LANES; g++) begin
        int idx;
        idx = g * LANES + l;
        if (idx < int'(width_of(width_sel_i)))
          lane_row[l] = lane_row[l] + abs_diff(src_row_i[idx*SAMPLE_W +: SAMPLE_W],
                                               ref_row_i[idx*SAMPLE_W +: SAMPLE_W]);
      end
      wide         = {1'b0, part[l]} + {1'b0, lane_row[l]};
      next_part[l] = wide[PART_W-1:0];
      carry        = carry | wide[PART_W];
      part_zero    = part_zero && (part[l] == '0);
      tot_zero     = tot_zero && (tot[l] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        part[l] <= '0;
        tot[l]  <= '0;
      end
    end else if (clr_i) begin
      for (int l = 0; l < LANES; l++) begin
        part[l] <= '0;
        tot[l]  <= '0;
      end
    end else if (fire_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (fold_i) begin
          tot[l]  <= tot[l] + {{(TOT_W-PART_W){1'b0}}, next_part[l]};
          part[l] <= '0;
        end else begin
          part[l] <= next_part[l];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign totals_o[l*TOT_W +: TOT_W] = tot[l];
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> !carry);
  // R4
  fold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && fold_i) |=> part_zero);
  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (part_zero && tot_zero));
endmodule

// File: rtl/quad_sad_engine.sv
module quad_sad_engine
  import quad_sad_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [1:0]                     width_sel_i,
  input  logic [HGT_W-1:0]               height_i,
  input  logic                           skip_i,
  input  logic                           row_valid_i,
  output logic                           row_ready_o,
  input  logic [MAX_W*SAMPLE_W-1:0]      src_row_i,
  input  logic [NREF*MAX_W*SAMPLE_W-1:0] ref_row_i,
  output logic                           done_o,
  output logic [NREF*TOT_W-1:0]          sad_o
);
  localparam int ROW_BITS = MAX_W * SAMPLE_W;

  logic       fire_w, fold_w, clr_w, reduce_w, skip_q;
  logic [1:0] width_q;
  logic [LANES*TOT_W-1:0] totals [NREF];
  logic [TOT_W-1:0]       reduced [NREF];

  sad_ctrl #(.H_W(HGT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_sel_i(width_sel_i),
    .height_i(height_i), .skip_i(skip_i), .row_valid_i(row_valid_i),
    .row_ready_o(row_ready_o), .fire_o(fire_w), .fold_o(fold_w), .clr_o(clr_w),
    .reduce_o(reduce_w), .width_q_o(width_q), .skip_q_o(skip_q)
  );

  for (genvar k = 0; k < NREF; k++) begin : g_ref
    sad_ref_path u_path (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .fire_i(fire_w), .fold_i(fold_w),
      .width_sel_i(width_q), .src_row_i(src_row_i),
      .ref_row_i(ref_row_i[k*ROW_BITS +: ROW_BITS]), .totals_o(totals[k])
    );

    always_comb begin
      logic [TOT_W-1:0] acc;
      acc = '0;
      for (int l = 0; l < LANES; l++) acc = acc + totals[k][l*TOT_W +: TOT_W];
      reduced[k] = skip_q ? (acc << 1) : acc;
    end

    // R5
    skip_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && skip_q) |-> !sad_o[k*TOT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= reduce_w;
      if (reduce_w)
        for (int k = 0; k < NREF; k++) sad_o[k*TOT_W +: TOT_W] <= reduced[k];
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reduce_w |=> $stable(sad_o));
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reduce_w || done_o) |-> !row_ready_o);
endmodule

// File: tb/quad_sad_engine_bench.sv
module quad_sad_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    wsel = '0;
  logic [6:0]    hgt = '0;
  logic          skip = 1'b0;
  logic          valid = 1'b0;
  logic          ready;
  logic [1023:0] src = '0;
  logic [4095:0] refs = '0;
  logic          done;
  logic [127:0]  sad;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_sad_engine u_quad_sad_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .width_sel_i(wsel), .height_i(hgt),
    .skip_i(skip), .row_valid_i(valid), .row_ready_o(ready), .src_row_i(src),
    .ref_row_i(refs), .done_o(done), .sad_o(sad)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill_row(input int w, input bit maxmode, inout longint exp [4]);
    for (int j = 0; j < 64; j++) begin
      logic [15:0] s;
      s = maxmode ? 16'd0 : 16'($urandom & 32'hFFF);
      if (j >= w) s = 16'($urandom);
      src[j*16 +: 16] = s;
      for (int k = 0; k < 4; k++) begin
        logic [15:0] r;
        r = maxmode ? 16'd4095 : 16'($urandom & 32'hFFF);
        if (j >= w) r = 16'($urandom);
        refs[k*1024 + j*16 +: 16] = r;
        if (j < w) exp[k] += (r > s) ? longint'(r - s) : longint'(s - r);
      end
    end
  endtask

  task automatic run_block(input logic [1:0] ws, input int h, input bit sk,
                           input bit maxmode, input bit poke, input bit hold,
                           input string tag);
    int w, beats, wait_cnt;
    longint exp [4];
    w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 32 : 64;
    beats = sk ? h / 2 : h;
    for (int k = 0; k < 4; k++) exp[k] = 0;
    @(negedge clk);
    wsel = ws; hgt = 7'(h); skip = sk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int b = 0; b < beats; b++) begin
      if ($urandom % 4 == 0) begin
        valid = 1'b0;
        @(negedge clk);
      end
      fill_row(w, maxmode, exp);
      valid = 1'b1;
      if (poke && b == beats / 2) begin
        start = 1'b1; wsel = 2'd0; hgt = 7'd8; skip = ~sk;
      end
      @(negedge clk);
      start = 1'b0;
    end
    if (hold) begin
      for (int k = 0; k < 4; k++) refs[k*1024 +: 16] = 16'd4095;
      src[15:0] = 16'd0;
    end else valid = 1'b0;
    // R8: after the last accepted row the engine stops taking beats
    check(ready == 1'b0, "R8 ready low after last row", longint'(ready), 0);
    wait_cnt = 0;
    while (!done && wait_cnt < 10) begin
      @(negedge clk);
      wait_cnt++;
    end
    check(done == 1'b1, "R7 done pulse seen", longint'(done), 1);
    for (int k = 0; k < 4; k++) begin
      longint e;
      e = (sk ? exp[k] * 2 : exp[k]) & 64'hFFFF_FFFF;
      check(longint'(sad[k*32 +: 32]) == e, tag, longint'(sad[k*32 +: 32]), e);
    end
    @(negedge clk);
    check(done == 1'b0, "R7 done lasts one cycle", longint'(done), 0);
    if (hold) check(ready == 1'b0, "R8 extra beats not consumed", longint'(ready), 0);
    valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(done == 1'b0, "R10 done after reset", longint'(done), 0);
    check(ready == 1'b0, "R10 ready after reset", longint'(ready), 0);
    check(sad == '0, "R10 results after reset", longint'(sad[31:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R5 R6: random sweep of every configuration, back to back
    for (int ws = 0; ws < 3; ws++)
      for (int hi = 0; hi < 4; hi++)
        for (int sk = 0; sk < 2; sk++)
          run_block(2'(ws), 8 << hi, sk[0], 1'b0, 1'b0, 1'b0,
                    sk ? "R5 skip random sum" : "R1 R2 R3 R6 random sum");
    // R4: every term at maximum for every configuration
    for (int ws = 0; ws < 3; ws++)
      for (int hi = 0; hi < 4; hi++)
        for (int sk = 0; sk < 2; sk++)
          run_block(2'(ws), 8 << hi, sk[0], 1'b1, 1'b0, 1'b0, "R4 max-difference sum");
    // R2: width code 3 behaves as 64
    run_block(2'd3, 16, 1'b0, 1'b1, 1'b0, 1'b0, "R2 width code 3");
    // R9: start during a block is ignored
    run_block(2'd2, 32, 1'b0, 1'b0, 1'b1, 1'b0, "R9 mid-block start ignored");
    run_block(2'd1, 16, 1'b1, 1'b1, 1'b1, 1'b0, "R9 mid-block start ignored skip");
    // R8: valid held after the last row
    run_block(2'd0, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R8 held valid result");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule